// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer that sits on a simple synchronous register bus with an address, a write strobe, write data and a combinational read-data return. A programmable down-counter loses one count on each pulse of a slow tick-enable input. When a tick arrives while the count is already zero, the timer has expired. It reloads itself from the programmed initial value and keeps running.

Expiry is handled in two stages. The first expiry only records a timeout flag. Software is expected to notice that flag and clear it. If a second expiry arrives while the flag is still set, the block records a second-timeout flag and issues a one-cycle system reset request. A separate no-reboot control bit can suppress that request, and the second-timeout flag is still recorded when it does. Software can halt the counter, force a reload, read the live count and clear the status flags by writing ones to them. A boot flag shows whether the previous reset was caused by the watchdog.

The stage is tracked by a state machine with four states:
- HALTED: the counter is frozen.
- STAGE1: running, no timeout pending.
- STAGE2: running, timeout pending.
- BITE: the one cycle after a second expiry.

Its transitions are:
- HALTED to STAGE1 or STAGE2 when the halt bit clears. The target depends on the timeout flag.
- STAGE1 to STAGE2 on the first expiry.
- STAGE2 to BITE on the second expiry.
- STAGE2 to STAGE1 when software clears the timeout flag.
- BITE to STAGE2 in the following cycle.
- Any running state to HALTED when the halt bit is set.

Top module: `wdog_two_stage`

## Requirements
- R1: Out of reset the halt bit is 1, the no-reboot bit is 1, the initial value and the live count are both 4, both timeout flags are 0, and reset_req_o is low.
- R2: A write of any data to offset 0x00 loads the counter with the current initial value. A read of offset 0x00 returns the live count in bits [9:0] and zeros above them.
- R3: The initial value lives at offset 0x12 in bits [9:0]. Write-data bits [15:10] are ignored there and read back as 0.
- R4: A write to offset 0x12 whose bits [9:0] are below 4 is ignored, and the previous initial value is kept.
- R5: The control register is at offset 0x08, with halt at bit 11. While halt is 1, ticks leave the count unchanged. While halt is 0, each tick lowers a nonzero count by one. Control bits other than 11 and 0 read as 0.
- R6: A tick that arrives with the count at 0 while no timeout is pending is a first expiry. It sets the timeout flag (offset 0x04, bit 3), reloads the counter from the initial value and raises no reset request.
- R7: A tick that arrives with the count at 0 while the timeout flag is set is a second expiry. It sets the second-timeout flag (offset 0x06, bit 1), reloads the counter, and drives reset_req_o high for exactly one cycle, starting in the cycle after the tick.
- R8: While the no-reboot bit (offset 0x08, bit 0) is 1, a second expiry still sets the second-timeout flag but reset_req_o stays low.
- R9: Status bits are write-one-to-clear, and writing 0 leaves them unchanged. Once the timeout flag is cleared, the next expiry is again a first expiry.
- R10: A reload write in the same cycle as a tick takes priority. The counter loads the initial value and that tick causes neither a decrement nor an expiry.
- R11: The boot flag (offset 0x06, bit 2) takes the value of boot_cause_i while reset is held. After that it ignores boot_cause_i and is cleared only by writing 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_cause_i | input | 1 | Tells the block, while reset is held, that the watchdog caused this reset |
| tick_en_i | input | 1 | One-cycle count tick, standing in for the slow time base |
| bus_addr_i | input | 5 | Byte offset of the register accessed |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W (16) | Write data |
| bus_rdata_o | output | DATA_W (16) | Read data for bus_addr_i, combinational |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench goes after these corner cases:
- A tick landing on a count of zero in each stage. A design that confuses the stages would pulse reset on the first expiry, or never pulse it at all.
- A reload colliding with such a tick. Getting the priority wrong would record a spurious timeout.
- Initial-value writes of 0 to 3. A missing guard would load a value the counter cannot use.
- Clearing the timeout flag with a second expiry pending. A machine that does not return to the first stage would reset the system after a single missed service.
- The no-reboot bit. A design that masks the flag along with the pulse would hide the event from software.
- Halting and resuming with a timeout pending. Resuming in the wrong stage would grant an extra stage or skip one.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Bus offsets (bytes from block base); software decodes these
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STS1   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_STS2   = 5'h06;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_INIT   = 5'h12;

    // Bit positions inside the status and control registers
    localparam int BIT_TO       = 3;   // status 1: first timeout
    localparam int BIT_SEC      = 1;   // status 2: second timeout
    localparam int BIT_BOOT     = 2;   // status 2: watchdog-caused boot
    localparam int BIT_HALT     = 11;  // control: counter halted
    localparam int BIT_NOREBOOT = 0;   // control: mask reset request

    typedef enum logic [1:0] {
        WD_HALTED = 2'd0,
        WD_STAGE1 = 2'd1,
        WD_STAGE2 = 2'd2,
        WD_BITE   = 2'd3
    } wd_state_e;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 10,
    parameter int INIT_MIN = 4,
    parameter int INIT_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_cause_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              ev_first_i,
    input  logic              ev_second_i,
    output logic              halt_o,
    output logic              no_reboot_o,
    output logic              to_sts_o,
    output logic              sec_sts_o,
    output logic [CNT_W-1:0]  init_o,
    output logic              reload_wr_o
);

    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(INIT_MIN);
    localparam logic [CNT_W-1:0] RST_V = CNT_W'(INIT_RST);

    logic wr_sts1, wr_sts2, wr_ctrl, wr_init;
    logic init_ok;
    logic halt_q, nr_q, to_q, sec_q, boot_q;
    logic [CNT_W-1:0] init_q;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata_i;

    always_comb begin
        reload_wr_o = bus_we_i && (bus_addr_i == OFS_RELOAD);
        wr_sts1     = bus_we_i && (bus_addr_i == OFS_STS1);
        wr_sts2     = bus_we_i && (bus_addr_i == OFS_STS2);
        wr_ctrl     = bus_we_i && (bus_addr_i == OFS_CTRL);
        wr_init     = bus_we_i && (bus_addr_i == OFS_INIT);
        init_ok     = (bus_wdata_i[CNT_W-1:0] >= MIN_V);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b1;
            nr_q   <= 1'b1;
            init_q <= RST_V;
            to_q   <= 1'b0;
            sec_q  <= 1'b0;
            boot_q <= boot_cause_i;
        end else begin
            if (wr_ctrl) begin
                halt_q <= bus_wdata_i[BIT_HALT];
                nr_q   <= bus_wdata_i[BIT_NOREBOOT];
            end
            if (wr_init && init_ok) begin
                init_q <= bus_wdata_i[CNT_W-1:0];
            end
            if (ev_first_i) begin
                to_q <= 1'b1;
            end else if (wr_sts1 && bus_wdata_i[BIT_TO]) begin
                to_q <= 1'b0;
            end
            if (ev_second_i) begin
                sec_q <= 1'b1;
            end else if (wr_sts2 && bus_wdata_i[BIT_SEC]) begin
                sec_q <= 1'b0;
            end
            if (wr_sts2 && bus_wdata_i[BIT_BOOT]) begin
                boot_q <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            OFS_RELOAD: bus_rdata_o[CNT_W-1:0] = cnt_i;
            OFS_STS1:   bus_rdata_o[BIT_TO]    = to_q;
            OFS_STS2: begin
                bus_rdata_o[BIT_SEC]  = sec_q;
                bus_rdata_o[BIT_BOOT] = boot_q;
            end
            OFS_CTRL: begin
                bus_rdata_o[BIT_HALT]     = halt_q;
                bus_rdata_o[BIT_NOREBOOT] = nr_q;
            end
            OFS_INIT:   bus_rdata_o[CNT_W-1:0] = init_q;
            default:    bus_rdata_o = '0;
        endcase
    end

    assign halt_o      = halt_q;
    assign no_reboot_o = nr_q;
    assign to_sts_o    = to_q;
    assign sec_sts_o   = sec_q;
    assign init_o      = init_q;

    AST_INIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        init_q >= MIN_V); // R4
    AST_INIT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_init && !init_ok) |=> $stable(init_q)); // R4
    AST_TO_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts1 && bus_wdata_i[BIT_TO] && !ev_first_i) |=> !to_q); // R9

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int CNT_W   = 10,
    parameter int CNT_RST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);

    localparam logic [CNT_W-1:0] RST_V = CNT_W'(CNT_RST);
    localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_V;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - ONE_V;
        end
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/wdog_stage_fsm.sv
module wdog_stage_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic reload_wr_i,
    input  logic halt_i,
    input  logic no_reboot_i,
    input  logic to_sts_i,
    input  logic zero_i,
    output logic run_o,
    output logic expire_o,
    output logic ev_first_o,
    output logic ev_second_o,
    output logic reset_req_o
);

    wd_state_e st_q, st_d;
    logic      req_q;

    always_comb begin
        run_o       = (st_q != WD_HALTED);
        expire_o    = ((st_q == WD_STAGE1) || (st_q == WD_STAGE2))
                      && tick_i && zero_i && !reload_wr_i;
        ev_first_o  = expire_o && (st_q == WD_STAGE1);
        ev_second_o = expire_o && (st_q == WD_STAGE2);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WD_HALTED: begin
                if (!halt_i) st_d = to_sts_i ? WD_STAGE2 : WD_STAGE1;
            end
            WD_STAGE1: begin
                if (halt_i)          st_d = WD_HALTED;
                else if (ev_first_o) st_d = WD_STAGE2;
            end
            WD_STAGE2: begin
                if (halt_i)           st_d = WD_HALTED;
                else if (ev_second_o) st_d = WD_BITE;
                else if (!to_sts_i)   st_d = WD_STAGE1;
            end
            WD_BITE: begin
                st_d = halt_i ? WD_HALTED : WD_STAGE2;
            end
            default: st_d = WD_HALTED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= WD_HALTED;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= ev_second_o && !no_reboot_i;
    end

    assign reset_req_o = req_q;

    AST_STAGE1_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WD_STAGE1) |=> !req_q); // R6

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 10,
    parameter int INIT_MIN = 4,
    parameter int INIT_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_cause_i,
    input  logic              tick_en_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              reset_req_o
);

    logic             halt, no_reboot, to_sts, sec_sts, reload_wr;
    logic [CNT_W-1:0] init_val, cnt;
    logic             zero, run, expire, ev_first, ev_second;
    logic             cnt_load, cnt_dec;

    wdog_regs #(
        .DATA_W  (DATA_W),
        .CNT_W   (CNT_W),
        .INIT_MIN(INIT_MIN),
        .INIT_RST(INIT_RST)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_cause_i(boot_cause_i),
        .bus_addr_i  (bus_addr_i),
        .bus_we_i    (bus_we_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .cnt_i       (cnt),
        .ev_first_i  (ev_first),
        .ev_second_i (ev_second),
        .halt_o      (halt),
        .no_reboot_o (no_reboot),
        .to_sts_o    (to_sts),
        .sec_sts_o   (sec_sts),
        .init_o      (init_val),
        .reload_wr_o (reload_wr)
    );

    assign cnt_load = reload_wr || expire;
    assign cnt_dec  = run && tick_en_i && !reload_wr;

    wdog_count #(
        .CNT_W  (CNT_W),
        .CNT_RST(INIT_RST)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (cnt_load),
        .load_val_i(init_val),
        .dec_i     (cnt_dec),
        .cnt_o     (cnt),
        .zero_o    (zero)
    );

    wdog_stage_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_en_i),
        .reload_wr_i (reload_wr),
        .halt_i      (halt),
        .no_reboot_i (no_reboot),
        .to_sts_i    (to_sts),
        .zero_i      (zero),
        .run_o       (run),
        .expire_o    (expire),
        .ev_first_o  (ev_first),
        .ev_second_o (ev_second),
        .reset_req_o (reset_req_o)
    );

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |=> !reset_req_o); // R7
    AST_REQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> sec_sts); // R7
    AST_REQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> !$past(no_reboot)); // R8
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload_wr) |=> $stable(cnt)); // R5
    AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reload_wr |=> (cnt == $past(init_val))); // R2
    AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt == $past(init_val))); // R6

endmodule

// File: tb/wdog_two_stage_tb.sv
module wdog_two_stage_tb;
    import wdog_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        boot_cause;
    logic        tick_en;
    logic [4:0]  bus_addr;
    logic        bus_we;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        reset_req;

    always #10 clk = ~clk;   // 50 MHz

    wdog_two_stage u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_cause_i(boot_cause),
        .tick_en_i   (tick_en),
        .bus_addr_i  (bus_addr),
        .bus_we_i    (bus_we),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .reset_req_o (reset_req)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    logic [9:0] m_cnt, m_init;
    bit m_halt, m_nr, m_to, m_sec, m_boot;

    task automatic check16(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(logic [4:0] a);
        logic [15:0] v = '0;
        case (a)
            OFS_RELOAD: v[9:0] = m_cnt;
            OFS_STS1:   v[BIT_TO] = m_to;
            OFS_STS2:   begin v[BIT_SEC] = m_sec; v[BIT_BOOT] = m_boot; end
            OFS_CTRL:   begin v[BIT_HALT] = m_halt; v[BIT_NOREBOOT] = m_nr; end
            OFS_INIT:   v[9:0] = m_init;
            default:    v = '0;
        endcase
        return v;
    endfunction

    function automatic string req_of(logic [4:0] a);
        case (a)
            OFS_RELOAD: return "R2";
            OFS_STS1:   return "R6";
            OFS_STS2:   return "R7";
            OFS_CTRL:   return "R5";
            default:    return "R3";
        endcase
    endfunction

    task automatic rd_chk(logic [4:0] a, string req);
        @(negedge clk);
        bus_we   = 1'b0;
        bus_addr = a;
        #1;
        check16(req, $sformatf("read 0x%02h", a), bus_rdata, exp_rd(a));
    endtask

    task automatic check_all();
        rd_chk(OFS_RELOAD, req_of(OFS_RELOAD));
        rd_chk(OFS_STS1,   req_of(OFS_STS1));
        rd_chk(OFS_STS2,   req_of(OFS_STS2));
        rd_chk(OFS_CTRL,   req_of(OFS_CTRL));
        rd_chk(OFS_INIT,   req_of(OFS_INIT));
    endtask

    task automatic model_write(logic [4:0] a, logic [15:0] d);
        case (a)
            OFS_RELOAD: m_cnt = m_init;
            OFS_STS1:   if (d[BIT_TO]) m_to = 1'b0;
            OFS_STS2: begin
                if (d[BIT_SEC])  m_sec  = 1'b0;
                if (d[BIT_BOOT]) m_boot = 1'b0;
            end
            OFS_CTRL: begin m_halt = d[BIT_HALT]; m_nr = d[BIT_NOREBOOT]; end
            OFS_INIT:   if (d[9:0] >= 10'd4) m_init = d[9:0];
            default: ;
        endcase
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        model_write(a, d);
        @(negedge clk);
    endtask

    // returns the expected reset pulse for one tick
    task automatic model_tick(output bit pulse);
        pulse = 1'b0;
        if (!m_halt) begin
            if (m_cnt == 10'd0) begin
                if (!m_to) m_to = 1'b1;
                else begin m_sec = 1'b1; pulse = !m_nr; end
                m_cnt = m_init;
            end else begin
                m_cnt = m_cnt - 10'd1;
            end
        end
    endtask

    task automatic tick(string req);
        bit p;
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        model_tick(p);
        check16(req, "reset_req after tick", {15'b0, reset_req}, {15'b0, p});
        @(negedge clk);
        check16("R7", "reset_req one cycle later", {15'b0, reset_req}, 16'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; boot_cause = 1'b1; tick_en = 1'b0;
        bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        boot_cause = 1'b0;
        m_cnt = 10'd4; m_init = 10'd4; m_halt = 1; m_nr = 1;
        m_to = 0; m_sec = 0; m_boot = 1;

        // R1 reset state
        rd_chk(OFS_RELOAD, "R1"); rd_chk(OFS_STS1, "R1");
        rd_chk(OFS_STS2, "R1");   rd_chk(OFS_CTRL, "R1");
        rd_chk(OFS_INIT, "R1");
        check16("R1", "reset_req", {15'b0, reset_req}, 16'h0);

        // R11 boot flag: input change ignored, zero write no effect, w1c
        repeat (2) @(negedge clk);
        rd_chk(OFS_STS2, "R11");
        wr(OFS_STS2, 16'h0000); rd_chk(OFS_STS2, "R11");
        wr(OFS_STS2, 16'h0004); rd_chk(OFS_STS2, "R11");

        // R5 halted: ticks ignored
        repeat (3) tick("R5");
        rd_chk(OFS_RELOAD, "R5");

        // R4 low values rejected, R3 upper bits ignored
        wr(OFS_INIT, 16'h0003); rd_chk(OFS_INIT, "R4");
        wr(OFS_INIT, 16'h0000); rd_chk(OFS_INIT, "R4");
        wr(OFS_INIT, 16'hFC06); rd_chk(OFS_INIT, "R3");

        // run, reload, count
        wr(OFS_CTRL, 16'h0000); rd_chk(OFS_CTRL, "R5");
        wr(OFS_RELOAD, 16'hBEEF); rd_chk(OFS_RELOAD, "R2");
        repeat (3) tick("R5");
        rd_chk(OFS_RELOAD, "R5");
        repeat (3) tick("R5");
        rd_chk(OFS_RELOAD, "R5");

        // R10 reload collides with a tick at count 0
        @(negedge clk);
        bus_addr = OFS_RELOAD; bus_wdata = 16'h0001; bus_we = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_en = 1'b0;
        m_cnt = m_init;
        @(negedge clk);
        rd_chk(OFS_RELOAD, "R10"); rd_chk(OFS_STS1, "R10");

        // R6 first expiry
        repeat (7) tick("R6");
        rd_chk(OFS_STS1, "R6"); rd_chk(OFS_RELOAD, "R6");
        // R7 second expiry with pulse
        repeat (7) tick("R7");
        rd_chk(OFS_STS2, "R7"); rd_chk(OFS_RELOAD, "R7");

        // R9 clear flags, back to first stage
        wr(OFS_STS1, 16'h0008); rd_chk(OFS_STS1, "R9");
        wr(OFS_STS2, 16'h0002); rd_chk(OFS_STS2, "R9");
        repeat (7) tick("R9");
        rd_chk(OFS_STS1, "R9"); rd_chk(OFS_STS2, "R9");

        // R8 no-reboot masks the pulse but keeps the flag
        wr(OFS_STS1, 16'h0008);
        wr(OFS_CTRL, 16'h0001);
        repeat (14) tick("R8");
        rd_chk(OFS_STS2, "R8");

        // halt with timeout pending, resume in second stage
        wr(OFS_STS2, 16'h0002);
        wr(OFS_CTRL, 16'h0800);
        repeat (2) tick("R5");
        wr(OFS_CTRL, 16'h0000);
        repeat (7) tick("R7");
        rd_chk(OFS_STS2, "R7");

        // constrained random phase
        for (int i = 0; i < 600; i++) begin
            int r;
            logic [15:0] d;
            r = int'($urandom % 100);
            if (r < 55) begin
                tick("R7");
            end else if (r < 62) begin
                wr(OFS_RELOAD, 16'($urandom));
            end else if (r < 70) begin
                d = {6'($urandom), 10'($urandom % 12)};
                wr(OFS_INIT, d);
            end else if (r < 78) begin
                d = 16'($urandom) & 16'hF7FE;
                if ($urandom % 5 == 0) d[BIT_HALT] = 1'b1;
                d[BIT_NOREBOOT] = 1'($urandom % 2);
                wr(OFS_CTRL, d);
            end else if (r < 87) begin
                wr(OFS_STS1, 16'($urandom));
            end else if (r < 95) begin
                wr(OFS_STS2, 16'($urandom));
            end else begin
                wr(5'h02, 16'hFFFF);
            end
            if (i % 4 == 3) check_all();
        end
        check_all();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule